// File: doc/BRIEF.md
# Latched Fixed-Priority Interrupt Acknowledger

This block accepts a set of interrupt request lines and answers with a one-hot acknowledge vector. The requests are not arbitrated continuously. Instead, a single-cycle evaluate strobe (`arb_go`) freezes the current request levels in a snapshot register. The acknowledge is then resolved from that frozen copy by a fixed-priority chain. A request that toggles while arbitration is under way therefore cannot produce a glitch or a second winner.

The acknowledge stays asserted until a single-cycle drop strobe (`ack_drop`) empties the snapshot. The number of request lines is a parameter. Line 0 always has the highest priority, and each further line is gated by a "nothing above me" term that is extended one stage per line. The whole block runs on one clock. Its asynchronous active-low reset is released through a short synchroniser.

Top module: `irq_latch_arbiter`

## Requirements
- R1: Priority is fixed by index: captured line 0 beats every other line, and a captured line i wins only when no line below index i was captured.
- R2: At most one bit of `irq_ack` is 1 at any time, and that bit is the lowest-index bit of the most recent snapshot.
- R3: When `arb_go` is 1 at a rising edge (and `ack_drop` is 0), `irq_req` is captured at that edge, and `irq_ack` shows the result from that edge on.
- R4: When `ack_drop` is 1 at a rising edge, `irq_ack` is all zero after that edge.
- R5: When `arb_go` and `ack_drop` are both 1 at the same edge, the drop takes effect and `irq_ack` is all zero.
- R6: A capture of an all-zero request vector leaves `irq_ack` all zero.
- R7: Changes on `irq_req` without `arb_go` leave `irq_ack` unchanged until the next capture or drop.
- R8: While `rst_n` is 0, `irq_ack` is all zero. The first two rising edges after `rst_n` returns to 1 ignore `arb_go`, and the third edge is the first one that can capture.
- R9: The line count `N_LINES` sets the width of `irq_req` and `irq_ack`, and the same priority rule holds at every width, including for the highest-index line when it is alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | N_LINES | Interrupt request levels, bit 0 highest priority |
| arb_go | input | 1 | Single-cycle strobe that captures `irq_req` |
| ack_drop | input | 1 | Single-cycle strobe that clears the held acknowledge |
| irq_ack | output | N_LINES | One-hot (or zero) acknowledge of the winning captured line |

## Verification
The bench builds two copies side by side, one with three lines and one with five lines, and drives both from the same request stimulus. The three-line copy sees only the low three request bits. With this setup, a pattern whose only set bits lie above bit 2 gives an empty result on the narrow copy and a real grant on the wide one, so the chain extension and the top line are both exercised. The five-line copy also reaches grants deeper in the chain than the narrow one can.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Action applied to the request snapshot on a clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2
  } snap_act_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/irq_arb_rst_sync.sv
module irq_arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/irq_arb_snapshot.sv
module irq_arb_snapshot
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               arb_go,
  input  logic               ack_drop,
  output logic [N_LINES-1:0] snap_q
);

  snap_act_e          act;
  logic               load_en;
  logic [N_LINES-1:0] snap_d;

  // Drop outranks capture when both strobes coincide
  always_comb begin
    if (ack_drop) begin
      act = ACT_CLEAR;
    end else if (arb_go) begin
      act = ACT_LOAD;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    case (act)
      ACT_LOAD:  snap_d = irq_req;
      ACT_CLEAR: snap_d = '0;
      default:   snap_d = snap_q;
    endcase
    load_en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (load_en) begin
      snap_q <= snap_d;
    end
  end

endmodule

// File: rtl/irq_arb_prio_chain.sv
module irq_arb_prio_chain #(
  parameter int unsigned N_LINES = 3
) (
  input  logic [N_LINES-1:0] snap,
  output logic [N_LINES-1:0] grant
);

  // blocked[i] is 1 when any line with index below i is captured
  logic [N_LINES:0] blocked;

  assign blocked[0] = 1'b0;

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_stage
      assign grant[i]     = snap[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | snap[i];
    end
  endgenerate

endmodule

// File: rtl/irq_latch_arbiter.sv
module irq_latch_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               arb_go,
  input  logic               ack_drop,
  output logic [N_LINES-1:0] irq_ack
);

  logic               rst_sync_n;
  logic [N_LINES-1:0] snap_q;

  irq_arb_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  irq_arb_snapshot #(
    .N_LINES(N_LINES)
  ) u_snapshot (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .irq_req (irq_req),
    .arb_go  (arb_go),
    .ack_drop(ack_drop),
    .snap_q  (snap_q)
  );

  irq_arb_prio_chain #(
    .N_LINES(N_LINES)
  ) u_prio (
    .snap (snap_q),
    .grant(irq_ack)
  );

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int unsigned N_LINES = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_q,
  input logic [N_LINES-1:0] irq_req,
  input logic               arb_go,
  input logic               ack_drop,
  input logic [N_LINES-1:0] irq_ack
);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  assert_top_line_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (arb_go && !ack_drop && irq_req[0]) |=> irq_ack[0]);

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (arb_go && !ack_drop && (irq_req != '0)) |=> (irq_ack != '0));

  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drop |=> (irq_ack == '0));

  assert_drop_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_go && ack_drop) |=> (irq_ack == '0));

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_go && (irq_req == '0)) |=> (irq_ack == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_go && !ack_drop) |=> $stable(irq_ack));

  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |-> (irq_ack == '0));

endmodule

bind irq_latch_arbiter irq_arb_checker #(
  .N_LINES(N_LINES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_q   (rst_sync_n),
  .irq_req (irq_req),
  .arb_go  (arb_go),
  .ack_drop(ack_drop),
  .irq_ack (irq_ack)
);

// File: tb/test_irq_latch_arbiter.sv
module test_irq_latch_arbiter;

  logic       clk;
  logic       rst_n;
  logic [4:0] req5;
  logic       go;
  logic       drop;
  logic [2:0] ack3;
  logic [4:0] ack5;

  int n_chk  = 0;
  int n_fail = 0;
  string phase = "R8";

  // Behavioural reference state
  logic [4:0] m_snap;
  int         m_rel;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  irq_latch_arbiter #(.N_LINES(3)) i_irq_latch_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_req(req5[2:0]),
    .arb_go(go), .ack_drop(drop), .irq_ack(ack3)
  );

  irq_latch_arbiter #(.N_LINES(5)) i_irq_latch_arbiter_w5 (
    .clk(clk), .rst_n(rst_n), .irq_req(req5),
    .arb_go(go), .ack_drop(drop), .irq_ack(ack5)
  );

  function automatic logic [4:0] lowest_set(logic [4:0] v, int n);
    logic [4:0] r;
    bit found;
    r = '0;
    found = 0;
    for (int i = 0; i < n; i++) begin
      if (v[i] && !found) begin
        r[i] = 1'b1;
        found = 1;
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ack=%b expected %b", tag, act, exp);
    end
  endtask

  // Reference model: two ignored edges after release, then drop beats capture
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_snap = '0;
      m_rel  = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else if (drop) begin
      m_snap = '0;
    end else if (go) begin
      m_snap = req5;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    check({phase, " model w3"}, {2'b00, ack3}, lowest_set(m_snap, 3));
    check({phase, " model w5"}, ack5, lowest_set(m_snap, 5));
  end

  task automatic apply(logic [4:0] v, logic g, logic d);
    @(negedge clk);
    req5 = v;
    go   = g;
    drop = d;
    @(negedge clk);
    go   = 1'b0;
    drop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req5  = '0;
    go    = 1'b0;
    drop  = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset w3", {2'b00, ack3}, 5'b0);
    check("R8 reset w5", ack5, 5'b0);

    // R8: capture strobe held over the two synchroniser edges is ignored
    rst_n = 1'b1;
    req5  = 5'b11111;
    go    = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 sync w3", {2'b00, ack3}, 5'b0);
    check("R8 sync w5", ack5, 5'b0);
    @(negedge clk);
    go = 1'b0;
    check("R3 first capture w3", {2'b00, ack3}, 5'b00001);
    check("R3 first capture w5", ack5, 5'b00001);

    phase = "R1";
    apply(5'b00110, 1'b1, 1'b0);
    check("R1 w3", {2'b00, ack3}, 5'b00010);
    check("R1 w5", ack5, 5'b00010);
    apply(5'b11100, 1'b1, 1'b0);
    check("R2 w3", {2'b00, ack3}, 5'b00100);
    check("R2 w5", ack5, 5'b00100);

    phase = "R9";
    apply(5'b11000, 1'b1, 1'b0);
    check("R9 w3 empty", {2'b00, ack3}, 5'b00000);
    check("R9 w5", ack5, 5'b01000);
    apply(5'b10000, 1'b1, 1'b0);
    check("R9 w5 top line", ack5, 5'b10000);

    phase = "R6";
    apply(5'b00000, 1'b1, 1'b0);
    check("R6 w3", {2'b00, ack3}, 5'b0);
    check("R6 w5", ack5, 5'b0);

    phase = "R7";
    apply(5'b00100, 1'b1, 1'b0);
    req5 = 5'b00001;
    repeat (3) @(negedge clk);
    check("R7 hold w3", {2'b00, ack3}, 5'b00100);
    check("R7 hold w5", ack5, 5'b00100);

    phase = "R4";
    apply(5'b00001, 1'b0, 1'b1);
    check("R4 w3", {2'b00, ack3}, 5'b0);
    check("R4 w5", ack5, 5'b0);

    phase = "R5";
    apply(5'b00010, 1'b1, 1'b0);
    check("R3 w5", ack5, 5'b00010);
    apply(5'b00001, 1'b1, 1'b1);
    check("R5 w3", {2'b00, ack3}, 5'b0);
    check("R5 w5", ack5, 5'b0);

    phase = "R2 random";
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      req5 = 5'($urandom);
      go   = ($urandom % 3) == 0;
      drop = ($urandom % 7) == 0;
    end
    @(negedge clk);
    go   = 1'b0;
    drop = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule